// File: doc/BRIEF.md
# Converter Serial Output Port with Clock-Mode Selection

This block drives the digital output side of a converter's serial port. It decides whether the serial clock is generated inside the block or supplied by the host. It shows conversion status on the data pin and shifts each 24-bit result frame out, most significant bit first. The clock source is chosen from the level seen on the clock pin when the power-up delay expires. It is chosen again on every high-to-low transition of the active-low chip select.

Results come from the conversion engine over a valid/ready handshake. A result is taken only in a cycle where `res_valid` and `res_ready` are both high. `res_ready` is high only while a conversion is running, and it is low from acceptance until the frame has left the port. The producer must hold `res_valid` and `res_data` until it sees ready. An offer made while ready is low is not taken. Chip select, the clock pin level and the pull-up flag are plain level signals. In the self-clocked mode, chip select may stay low permanently, and frames then follow one another without host action.

Top module: `adc_serout_ctrl`

## Requirements
- R1: After `rst_n` rises, a power-up phase lasts exactly POR_CYCLES clocks. During it `res_ready`=0, `sck_oe`=0 and `sdo`=1.
- R2: `pullup_en` is 0 whenever `sck_pin` is 0. Otherwise it is 1 during power-up and in self-clocked mode, and 0 in host-clocked mode.
- R3: When power-up ends, `sck_pin`=1 selects self-clocked mode (`sck_oe`=1) and `sck_pin`=0 selects host-clocked mode (`sck_oe`=0).
- R4: After power-up, a falling edge on `cs_n` samples `sck_pin`: 0 selects host-clocked mode and 1 selects self-clocked mode, from the next cycle on.
- R5: While converting (`res_ready`=1), `sdo`=1 and, in self-clocked mode, `sck_out`=1.
- R6: An accepted result makes `sdo`=0, `res_ready`=0 and `sck_out`=0 in the next cycle. A `res_valid` pulse while `res_ready`=0 is ignored, and the frame sent is the earlier one.
- R7: The frame is 24 bits, sent from bit 23 down to bit 0. Bit 23 is 0 (end-of-conversion flag), bit 22 is a fixed 0, bit 21 is `res_data[21]` (sign), and bits 20..0 are `res_data[20:0]`.
- R8: In self-clocked mode with `cs_n` low, `sck_out` rises once per bit, every 2*HALF_CYC clocks. `sdo` is stable while `sck_out` stays high. HALF_CYC clocks after the 24th rise, `sck_out` stays high and a new conversion starts (`res_ready`=1, `sdo`=1).
- R9: In host-clocked mode with `cs_n` low, `sdo` moves to the next bit on each falling edge of `sck_pin`. The 24th falling edge starts a new conversion.
- R10: `cs_n` rising during a frame abandons it, and the next cycle shows a running conversion (`res_ready`=1, `sdo`=1).
- R11: With `cs_n` held low in self-clocked mode, successive results stream out back to back with no host action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-good reset |
| cs_n | input | 1 | Active-low chip select level |
| sck_pin | input | 1 | Sampled level of the serial clock pin |
| res_valid | input | 1 | Conversion result offered |
| res_data | input | DATA_W | Result: sign bit at the top, then magnitude |
| res_ready | output | 1 | Conversion running, result can be taken |
| sdo | output | 1 | Serial data / status output |
| sck_out | output | 1 | Clock level driven in self-clocked mode |
| sck_oe | output | 1 | Drive enable for the clock pin |
| pullup_en | output | 1 | Weak pull-up enable for the clock pin |

## Verification
Five result words run through the self-clocked stream with chip select held low. They are all ones, all zeros, alternating bits, the opposite alternation, and a word with only the sign and LSB set. Between them they expose a stuck or swapped frame bit, a wrong bit order, and a miscounted final bit. The host-clocked path is then driven with slow manual clock pulses. That run separates shifting on the falling edge from shifting on the rising edge, and it places an ignored second offer ahead of the frame. Directed chip-select edges, taken with the clock pin high and low, tell a correctly re-chosen clock source from a stale one. An aborted frame shows whether a rising chip select restarts conversion.

// File: rtl/adc_so_pkg.sv
`timescale 1ns/1ps
package adc_so_pkg;
  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,  // conversion running, end-of-conversion flag high
    ST_READY = 2'd1,  // result held, waiting for chip select
    ST_SHIFT = 2'd2   // frame leaving the port
  } ser_state_e;
endpackage

// File: rtl/adc_so_por_timer.sv
`timescale 1ns/1ps
module adc_so_por_timer #(
  parameter int POR_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic por_active,
  output logic por_end
);
  localparam int CW = $clog2(POR_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      por_active <= 1'b1;
    end else if (por_active) begin
      if (cnt_q == CW'(POR_CYCLES - 1)) por_active <= 1'b0;
      else                              cnt_q      <= cnt_q + 1'b1;
    end
  end

  assign por_end = por_active && (cnt_q == CW'(POR_CYCLES - 1));
endmodule

// File: rtl/adc_so_mode_sel.sv
`timescale 1ns/1ps
module adc_so_mode_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic por_active,
  input  logic por_end,
  input  logic cs_n,
  input  logic sck_pin,
  output logic int_mode,
  output logic cs_rise
);
  logic cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      int_mode <= 1'b1;
    end else begin
      cs_q <= cs_n;
      if (por_end)                           int_mode <= sck_pin;
      else if (!por_active && cs_q && !cs_n) int_mode <= sck_pin;
    end
  end

  assign cs_rise = !cs_q && cs_n;
endmodule

// File: rtl/adc_so_serializer.sv
`timescale 1ns/1ps
module adc_so_serializer
  import adc_so_pkg::*;
#(
  parameter int DATA_W   = 22,
  parameter int HALF_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_active,
  input  logic              int_mode,
  input  logic              cs_n,
  input  logic              cs_rise,
  input  logic              sck_pin,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  output logic              res_ready,
  output logic              sdo,
  output logic              sck_drv
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int DIV_W   = $clog2(HALF_CYC + 1);

  ser_state_e         state_q;
  logic [FRAME_W-1:0] frame_q;
  logic [IDX_W-1:0]   idx_q;
  logic               ph_q;
  logic [DIV_W-1:0]   dcnt_q;
  logic               sck_q;

  always_ff @(posedge clk) begin
    if (!rst_n || por_active) begin
      state_q <= ST_CONV;
      frame_q <= '0;
      idx_q   <= '0;
      ph_q    <= 1'b1;
      dcnt_q  <= '0;
      sck_q   <= 1'b1;
    end else begin
      sck_q <= sck_pin;
      unique case (state_q)
        ST_CONV: begin
          if (res_valid) begin
            frame_q <= {2'b00, res_data};
            state_q <= ST_READY;
          end
        end
        ST_READY: begin
          if (!cs_n) begin
            state_q <= ST_SHIFT;
            idx_q   <= IDX_W'(FRAME_W - 1);
            ph_q    <= 1'b1;
            dcnt_q  <= '0;
          end
        end
        ST_SHIFT: begin
          if (cs_rise) begin
            state_q <= ST_CONV;
            ph_q    <= 1'b1;
          end else if (int_mode) begin
            if (dcnt_q == DIV_W'(HALF_CYC - 1)) begin
              dcnt_q <= '0;
              if (ph_q) begin
                if (idx_q == '0) state_q <= ST_CONV;
                else begin
                  ph_q  <= 1'b0;
                  idx_q <= idx_q - 1'b1;
                end
              end else begin
                ph_q <= 1'b1;
              end
            end else begin
              dcnt_q <= dcnt_q + 1'b1;
            end
          end else if (sck_q && !sck_pin) begin
            if (idx_q == '0) state_q <= ST_CONV;
            else             idx_q   <= idx_q - 1'b1;
          end
        end
        default: state_q <= ST_CONV;
      endcase
    end
  end

  always_comb begin
    res_ready = 1'b0;
    sdo       = 1'b1;
    sck_drv   = 1'b1;
    unique case (state_q)
      ST_CONV: res_ready = !por_active;
      ST_READY: begin
        sdo     = frame_q[FRAME_W-1];
        sck_drv = 1'b0;
      end
      ST_SHIFT: begin
        sdo     = frame_q[idx_q];
        sck_drv = ph_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/adc_serout_ctrl.sv
`timescale 1ns/1ps
module adc_serout_ctrl #(
  parameter int DATA_W     = 22,
  parameter int POR_CYCLES = 100000,
  parameter int HALF_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck_pin,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  output logic              res_ready,
  output logic              sdo,
  output logic              sck_out,
  output logic              sck_oe,
  output logic              pullup_en
);
  logic por_active, por_end, int_mode, cs_rise;

  adc_so_por_timer #(.POR_CYCLES(POR_CYCLES)) por_i (
    .clk(clk), .rst_n(rst_n), .por_active(por_active), .por_end(por_end)
  );

  adc_so_mode_sel mode_i (
    .clk(clk), .rst_n(rst_n), .por_active(por_active), .por_end(por_end),
    .cs_n(cs_n), .sck_pin(sck_pin), .int_mode(int_mode), .cs_rise(cs_rise)
  );

  adc_so_serializer #(.DATA_W(DATA_W), .HALF_CYC(HALF_CYC)) ser_i (
    .clk(clk), .rst_n(rst_n), .por_active(por_active), .int_mode(int_mode),
    .cs_n(cs_n), .cs_rise(cs_rise), .sck_pin(sck_pin),
    .res_valid(res_valid), .res_data(res_data), .res_ready(res_ready),
    .sdo(sdo), .sck_drv(sck_out)
  );

  assign sck_oe    = int_mode && !por_active;
  assign pullup_en = sck_pin && (por_active || int_mode);
endmodule

// File: rtl/adc_serout_ctrl_chk.sv
`timescale 1ns/1ps
module adc_serout_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck_pin,
  input logic res_valid,
  input logic res_ready,
  input logic sdo,
  input logic sck_out,
  input logic sck_oe,
  input logic pullup_en,
  input logic por_active
);
  a_r2_pullup_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_pin |-> !pullup_en);

  a_r1_no_drive_in_por: assert property (@(posedge clk) disable iff (!rst_n)
    por_active |-> (!sck_oe && !res_ready && sdo));

  a_r5_busy_flag_high: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |-> sdo);

  a_r6_accept_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> (!sdo && !res_ready));

  a_r8_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_oe && $past(sck_oe) && sck_out && $past(sck_out) && !res_ready)
      |-> $stable(sdo));

  a_r4_cs_fall_low_ext: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && !sck_pin && !por_active) |=> !sck_oe);
endmodule

bind adc_serout_ctrl adc_serout_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_pin(sck_pin),
  .res_valid(res_valid), .res_ready(res_ready), .sdo(sdo),
  .sck_out(sck_out), .sck_oe(sck_oe), .pullup_en(pullup_en),
  .por_active(por_active)
);

// File: tb/adc_serout_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_serout_ctrl_tb_top;
  localparam int DATA_W = 22;
  localparam int POR_C  = 8;
  localparam int HALF   = 2;
  localparam int NVEC   = 5;
  localparam logic [DATA_W-1:0] VEC [NVEC] = '{
    22'h3FFFFF, 22'h000000, 22'h2AAAAA, 22'h155555, 22'h200001
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic ext_sck = 1'b1;
  logic res_valid = 1'b0;
  logic [DATA_W-1:0] res_data = '0;
  logic res_ready, sdo, sck_out, sck_oe, pullup_en, sck_pin;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  assign sck_pin = sck_oe ? sck_out : ext_sck;

  always #2 clk = ~clk;

  adc_serout_ctrl #(.DATA_W(DATA_W), .POR_CYCLES(POR_C), .HALF_CYC(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_pin(sck_pin),
    .res_valid(res_valid), .res_data(res_data), .res_ready(res_ready),
    .sdo(sdo), .sck_out(sck_out), .sck_oe(sck_oe), .pullup_en(pullup_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic pin, input logic cs);
    @(negedge clk);
    rst_n = 1'b0; ext_sck = pin; cs_n = cs; res_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic offer(input logic [DATA_W-1:0] d);
    res_valid = 1'b1; res_data = d;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  // Self-clocked frame capture, called one cycle after acceptance (READY).
  task automatic grab_internal(input logic [DATA_W-1:0] d, input int k);
    logic [23:0] word = '0;
    int n = 0, cyc = 0, last = 0, guard = 0;
    bit stable_ok = 1'b1, period_ok = 1'b1;
    logic psck = sck_out, psdo = sdo;
    while (n < 24 && guard < 2000) begin
      @(negedge clk);
      guard++; cyc++;
      if (!psck && sck_out) begin
        if (n > 0 && (cyc - last) != 2 * HALF) period_ok = 1'b0;
        word[23-n] = sdo;
        n++;
        last = cyc;
      end else if (psck && sck_out && sdo !== psdo) begin
        stable_ok = 1'b0;
      end
      psck = sck_out; psdo = sdo;
    end
    chk($sformatf("R7 frame vec%0d", k), {8'h0, word}, {8'h0, 2'b00, d});
    chk("R8 sdo stable while clock high", {31'd0, stable_ok}, 32'd1);
    chk("R8 rise spacing", {31'd0, period_ok}, 32'd1);
    repeat (HALF - 1) @(negedge clk);
    chk("R8 last high phase not ended", {31'd0, res_ready}, 32'd0);
    @(negedge clk);
    chk("R8 R11 next conversion ready", {29'd0, res_ready, sdo, sck_out}, 32'h7);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // ---- Self-clocked start, chip select tied low ----
    do_reset(1'b1, 1'b0);
    chk("R1 reset state", {29'd0, res_ready, sck_oe, sdo}, 32'h1);
    chk("R2 pull-up during power-up", {31'd0, pullup_en}, 32'd1);
    ext_sck = 1'b0; #1;
    chk("R2 pull-up off when pin low", {31'd0, pullup_en}, 32'd0);
    ext_sck = 1'b1;
    repeat (POR_C - 1) @(negedge clk);
    chk("R1 power-up still active", {30'd0, res_ready, sck_oe}, 32'd0);
    @(negedge clk);
    chk("R3 pin high selects self clock", {31'd0, sck_oe}, 32'd1);
    chk("R5 converting levels", {29'd0, res_ready, sdo, sck_out}, 32'h7);

    // ---- Vector table streamed back to back (R7, R8, R11) ----
    for (int i = 0; i < NVEC; i++) begin
      offer(VEC[i]);
      chk("R6 accept drops flag and clock", {29'd0, sdo, sck_out, res_ready}, 32'd0);
      chk("R2 pull-up off with clock low", {31'd0, pullup_en}, 32'd0);
      grab_internal(VEC[i], i);
    end

    // ---- Host-clocked start ----
    do_reset(1'b0, 1'b1);
    repeat (POR_C + 1) @(negedge clk);
    chk("R3 pin low selects host clock", {31'd0, sck_oe}, 32'd0);
    ext_sck = 1'b1; #1;
    chk("R2 no pull-up in host mode", {31'd0, pullup_en}, 32'd0);
    ext_sck = 1'b0;
    offer(22'h2C0F35);
    chk("R6 accepted", {30'd0, res_ready, sdo}, 32'd0);
    offer(22'h1111AB);
    chk("R6 offer while busy ignored", {30'd0, res_ready, sdo}, 32'd0);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 fall with pin low keeps host clock", {31'd0, sck_oe}, 32'd0);
    begin
      logic [23:0] w = '0;
      for (int b = 0; b < 24; b++) begin
        ext_sck = 1'b1;
        repeat (2) @(negedge clk);
        w[23-b] = sdo;
        ext_sck = 1'b0;
        repeat (2) @(negedge clk);
      end
      chk("R9 R6 host frame keeps first result", {8'h0, w}, {8'h0, 2'b00, 22'h2C0F35});
    end
    chk("R9 conversion after 24th fall", {30'd0, res_ready, sdo}, 32'h3);

    // ---- Abort by chip select rising (R10) ----
    offer(22'h0F0F0F);
    @(negedge clk);
    for (int b = 0; b < 3; b++) begin
      ext_sck = 1'b1; repeat (2) @(negedge clk);
      ext_sck = 1'b0; repeat (2) @(negedge clk);
    end
    chk("R10 mid-frame busy", {31'd0, res_ready}, 32'd0);
    cs_n = 1'b1;
    @(negedge clk);
    chk("R10 abort restarts conversion", {30'd0, res_ready, sdo}, 32'h3);

    // ---- Mode re-selection on chip select falls (R4) ----
    ext_sck = 1'b1;
    @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    chk("R4 fall with pin high selects self clock", {30'd0, sck_oe, sck_out}, 32'h3);
    cs_n = 1'b1;
    @(negedge clk);
    offer(22'h012345);
    chk("R6 self-clocked waits with clock low", {30'd0, sck_out, sdo}, 32'd0);
    cs_n = 1'b0;
    @(negedge clk);
    chk("R4 fall with clock low selects host clock", {31'd0, sck_oe}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule